// File: doc/BRIEF.md
# Late-Write Double-Rate Burst Memory Core

This block is a synchronous, pipelined static memory core with a posted-write path. Every rising clock edge samples an address, three active-low control strobes and a double-width write data word. A sampled command either loads a fresh address or advances the burst position of the address loaded last. It is a read or a write, and it moves a single word (single rate) or two words (double rate). A double-rate read presents its first word while the clock is high and its second word while the clock is low. The data for a write arrives on the edge after its command. That data waits in a write buffer and is committed to the array only when the data of a later write is captured.

Reads compare each beat address against the buffered entries. When an address matches, the buffered word is returned instead of the stale array contents, so a read issued straight after a write to the same location still sees the new data. The position inside an aligned group of four words advances in either wrap-around order or exclusive-or order. The order is chosen per burst by a strap input that is latched when the address is loaded. An asynchronous active-low output enable releases the data pins.

Top module: `lwb_sram_core`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), the data outputs read 0, the write buffer is empty, and every array word reads 0.
- R2: A command is sampled when ld_n is 0. A single-rate read (wr_n=1, ddr_n=1) sampled at edge k makes q carry the word at the loaded address during the whole cycle that starts at edge k+1.
- R3: A double-rate read (ddr_n=0) sampled at edge k makes q show beat 0 while the clock is high and beat 1 while the clock is low, in the cycle that starts at edge k+1. Both beats share address bits [AW-1:2].
- R4: When interleave was 0 at the load, the low two address bits of beat j are (start + position + j) mod 4. Here start is addr[1:0] at the load.
- R5: When interleave was 1 at the load, the low two address bits of beat j are start XOR (position + j), with the sum taken mod 4.
- R6: A cycle with ld_n=1 continues the last loaded burst. The position starts at 0 on a load and advances by 2 for a double-rate burst or by 1 for a single-rate burst, mod 4. The read/write and rate of the load are kept, and wr_n and ddr_n are ignored. Before the first load after reset, a cycle with ld_n=1 does nothing.
- R7: Write data is taken on the edge after its write command. wdata[DW-1:0] is beat 0 and wdata[2*DW-1:DW] is beat 1. A single-rate write uses only beat 0.
- R8: A read whose beat address matches an entry still held in the write buffer returns the buffered word. This includes a read issued on the cycle right after the write command.
- R9: Buffered words are committed to the array on the edge that captures the data of the next write. Later reads of those addresses return the committed words.
- R10: While oe_n is 1, q is released to high impedance at once, without waiting for a clock edge.
- R11: After a single-rate read, q holds the same word in both clock phases. The output registers keep their value during cycles that load no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Commands are sampled on the rising edge, and the low phase carries the second read beat |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address, sampled on loads |
| ld_n | input | 1 | 0 loads a new address, 1 continues the current burst |
| wr_n | input | 1 | 0 write, 1 read (sampled on loads) |
| ddr_n | input | 1 | 0 two-beat double-rate burst, 1 single word (sampled on loads) |
| interleave | input | 1 | Burst order: 1 exclusive-or order, 0 wrap-around order (sampled on loads) |
| wdata | input | 2*DW | Write data for the write command sampled one edge earlier; low half is beat 0 |
| oe_n | input | 1 | Asynchronous active-low output enable |
| q | output | DW | Read data, released to high impedance while oe_n is 1 |

## Verification
The bench builds the core with AW=5 and DW=16, which gives a 32-word array. At that depth, random addresses often hit a word that is still waiting in the write buffer, so coherence under a buffer hit, commit on the next write and plain array reads all occur many times. Every start offset inside a group of four words is reached in both burst orders. Continuation chains of writes and reads wrap past position 3. The narrow data width keeps the random write data distinct from the reset value of zero.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

  // Low two address bits of one beat, given the burst start, the current
  // position and the selected order.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] pos,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ pos;
    else     r = start + pos;
    return r;
  endfunction

  // Position increment applied by a continuation cycle.
  function automatic logic [1:0] pos_step(input logic ddr);
    return ddr ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/lwb_seq.sv
module lwb_seq
  import lwb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          wr_n,
  input  logic          ddr_n,
  input  logic          ilv_in,
  input  logic [AW-1:0] addr,
  output logic          s1_valid,
  output logic          s1_wr,
  output logic          s1_ddr,
  output logic [1:0]    s1_pos,
  output logic          adv_fire,
  output logic [AW-1:0] beat_a0,
  output logic [AW-1:0] beat_a1
);
  localparam int HW = AW - 2;

  logic          act;
  logic [HW-1:0] base;
  logic [1:0]    start;
  logic          ilv;

  assign adv_fire = ld_n && act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= 1'b0;
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_ddr   <= 1'b0;
      s1_pos   <= 2'd0;
      base     <= '0;
      start    <= 2'd0;
      ilv      <= 1'b0;
    end else if (!ld_n) begin
      act      <= 1'b1;
      s1_valid <= 1'b1;
      s1_wr    <= !wr_n;
      s1_ddr   <= !ddr_n;
      s1_pos   <= 2'd0;
      base     <= addr[AW-1:2];
      start    <= addr[1:0];
      ilv      <= ilv_in;
    end else if (adv_fire) begin
      s1_valid <= 1'b1;
      s1_pos   <= s1_pos + pos_step(s1_ddr);
    end else begin
      s1_valid <= 1'b0;
    end
  end

  assign beat_a0 = {base, beat_low(start, s1_pos, ilv)};
  assign beat_a1 = {base, beat_low(start, s1_pos + 2'd1, ilv)};

endmodule

// File: rtl/lwb_wbuf.sv
module lwb_wbuf #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          take_ddr,
  input  logic [AW-1:0] take_a0,
  input  logic [AW-1:0] take_a1,
  input  logic [2*DW-1:0] wdata,
  input  logic [AW-1:0] look_a0,
  input  logic [AW-1:0] look_a1,
  output logic          hit0,
  output logic          hit1,
  output logic [DW-1:0] hit_d0,
  output logic [DW-1:0] hit_d1,
  output logic          commit_fire,
  output logic [1:0]    commit_v,
  output logic [AW-1:0] commit_a0,
  output logic [AW-1:0] commit_a1,
  output logic [DW-1:0] commit_d0,
  output logic [DW-1:0] commit_d1
);
  logic [1:0]    ent_v;
  logic [AW-1:0] ent_a [2];
  logic [DW-1:0] ent_d [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= 2'b00;
      for (int i = 0; i < 2; i++) begin
        ent_a[i] <= '0;
        ent_d[i] <= '0;
      end
    end else if (take) begin
      ent_v    <= {take_ddr, 1'b1};
      ent_a[0] <= take_a0;
      ent_a[1] <= take_a1;
      ent_d[0] <= wdata[DW-1:0];
      ent_d[1] <= wdata[2*DW-1:DW];
    end
  end

  // Per-beat lookup against both buffered entries.
  logic [AW-1:0] look [2];
  logic [1:0]    hits;
  logic [DW-1:0] hd [2];
  assign look[0] = look_a0;
  assign look[1] = look_a1;

  for (genvar b = 0; b < 2; b++) begin : g_look
    always_comb begin
      hits[b] = 1'b0;
      hd[b]   = '0;
      for (int e = 0; e < 2; e++) begin
        if (ent_v[e] && ent_a[e] == look[b]) begin
          hits[b] = 1'b1;
          hd[b]   = ent_d[e];
        end
      end
    end
  end

  assign hit0   = hits[0];
  assign hit1   = hits[1];
  assign hit_d0 = hd[0];
  assign hit_d1 = hd[1];

  assign commit_fire = take && (ent_v != 2'b00);
  assign commit_v    = ent_v;
  assign commit_a0   = ent_a[0];
  assign commit_a1   = ent_a[1];
  assign commit_d0   = ent_d[0];
  assign commit_d1   = ent_d[1];

endmodule

// File: rtl/lwb_outstage.sv
module lwb_outstage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d0,
  input  logic [DW-1:0] d1,
  input  logic          oe_n,
  output logic [DW-1:0] r0,
  output logic [DW-1:0] r1,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r0 <= '0;
      r1 <= '0;
    end else if (load) begin
      r0 <= d0;
      r1 <= d1;
    end
  end

  logic [DW-1:0] drv;
  assign drv = clk ? r0 : r1;
  assign q   = oe_n ? {DW{1'bz}} : drv;

endmodule

// File: rtl/lwb_sram_core.sv
module lwb_sram_core
  import lwb_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            ld_n,
  input  logic            wr_n,
  input  logic            ddr_n,
  input  logic            interleave,
  input  logic [2*DW-1:0] wdata,
  input  logic            oe_n,
  output logic [DW-1:0]   q
);
  localparam int DEPTH = 1 << AW;

  logic          s1_valid, s1_wr, s1_ddr, adv_fire;
  logic [1:0]    s1_pos;
  logic [AW-1:0] beat_a0, beat_a1;

  lwb_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_n     (ld_n),
    .wr_n     (wr_n),
    .ddr_n    (ddr_n),
    .ilv_in   (interleave),
    .addr     (addr),
    .s1_valid (s1_valid),
    .s1_wr    (s1_wr),
    .s1_ddr   (s1_ddr),
    .s1_pos   (s1_pos),
    .adv_fire (adv_fire),
    .beat_a0  (beat_a0),
    .beat_a1  (beat_a1)
  );

  // Named events for the checker.
  logic wr_take, rd_fire;
  assign wr_take = s1_valid && s1_wr;
  assign rd_fire = s1_valid && !s1_wr;

  logic          hit0, hit1, commit_fire;
  logic [DW-1:0] hit_d0, hit_d1, commit_d0, commit_d1;
  logic [1:0]    commit_v;
  logic [AW-1:0] commit_a0, commit_a1;

  lwb_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (wr_take),
    .take_ddr    (s1_ddr),
    .take_a0     (beat_a0),
    .take_a1     (beat_a1),
    .wdata       (wdata),
    .look_a0     (beat_a0),
    .look_a1     (beat_a1),
    .hit0        (hit0),
    .hit1        (hit1),
    .hit_d0      (hit_d0),
    .hit_d1      (hit_d1),
    .commit_fire (commit_fire),
    .commit_v    (commit_v),
    .commit_a0   (commit_a0),
    .commit_a1   (commit_a1),
    .commit_d0   (commit_d0),
    .commit_d1   (commit_d1)
  );

  logic buf_v0;
  assign buf_v0 = commit_v[0];

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_fire) begin
      if (commit_v[0]) mem[commit_a0] <= commit_d0;
      if (commit_v[1]) mem[commit_a1] <= commit_d1;
    end
  end

  logic [DW-1:0] rd0, rd1, ld1;
  assign rd0 = hit0 ? hit_d0 : mem[beat_a0];
  assign rd1 = hit1 ? hit_d1 : mem[beat_a1];
  assign ld1 = s1_ddr ? rd1 : rd0;

  logic [DW-1:0] out_r0, out_r1;

  lwb_outstage #(.DW(DW)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_fire),
    .d0    (rd0),
    .d1    (ld1),
    .oe_n  (oe_n),
    .r0    (out_r0),
    .r1    (out_r1),
    .q     (q)
  );

endmodule

// File: rtl/lwb_sram_core_chk.sv
module lwb_sram_core_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv_fire,
  input logic          s1_ddr,
  input logic [1:0]    s1_pos,
  input logic          wr_take,
  input logic          rd_fire,
  input logic          commit_fire,
  input logic          buf_v0,
  input logic          hit0,
  input logic [DW-1:0] hit_d0,
  input logic [DW-1:0] out_r0,
  input logic [DW-1:0] out_r1
);
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_fire |=> s1_pos == 2'($past(s1_pos) + ($past(s1_ddr) ? 2'd2 : 2'd1))); // R6

  AST_BUF_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> buf_v0); // R7

  AST_HIT_SERVES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && hit0) |=> out_r0 == $past(hit_d0)); // R8

  AST_COMMIT_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> wr_take); // R9

  AST_SDR_BOTH_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !s1_ddr) |=> out_r0 == out_r1); // R11

endmodule

bind lwb_sram_core lwb_sram_core_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adv_fire    (adv_fire),
  .s1_ddr      (s1_ddr),
  .s1_pos      (s1_pos),
  .wr_take     (wr_take),
  .rd_fire     (rd_fire),
  .commit_fire (commit_fire),
  .buf_v0      (buf_v0),
  .hit0        (hit0),
  .hit_d0      (hit_d0),
  .out_r0      (out_r0),
  .out_r1      (out_r1)
);

// File: tb/lwb_sram_core_tb.sv
module lwb_sram_core_tb;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1 << AW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic            ld_n = 1'b1, wr_n = 1'b1, ddr_n = 1'b1, interleave = 1'b0;
  logic [2*DW-1:0] wdata = '0;
  logic            oe_n = 1'b0;
  logic [DW-1:0]   q;

  lwb_sram_core #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ld_n(ld_n), .wr_n(wr_n),
    .ddr_n(ddr_n), .interleave(interleave), .wdata(wdata), .oe_n(oe_n), .q(q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int bad = 0;

  // Behavioural reference: the memory a reader should observe.
  logic [DW-1:0] ref_mem [DEPTH];
  int m_act = 0, m_base = 0, m_start = 0, m_pos = 0, m_wr = 0, m_ddr = 0, m_ilv = 0;
  int pw_valid = 0, pw_ddr = 0, pw_a0 = 0, pw_a1 = 0;
  logic [DW-1:0] cur0 = '0, cur1 = '0, nxt0 = '0, nxt1 = '0;

  function automatic int low_of(int start, int p, int ilv);
    if (ilv != 0) return start ^ (p % 4);
    return (start + p) % 4;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, let the edge sample them, update the model,
  // then compare q in the high phase and in the low phase.
  task automatic step(input logic l, input logic w, input logic d, input logic il,
                      input int a, input logic [2*DW-1:0] wd, input string tag);
    int valid;
    int a0, a1;
    ld_n = l; wr_n = w; ddr_n = d; interleave = il; addr = AW'(a); wdata = wd;
    @(posedge clk);
    if (pw_valid != 0) begin
      ref_mem[pw_a0] = wd[DW-1:0];
      if (pw_ddr != 0) ref_mem[pw_a1] = wd[2*DW-1:DW];
      pw_valid = 0;
    end
    cur0 = nxt0; cur1 = nxt1;
    valid = 0;
    if (l == 1'b0) begin
      m_act = 1; m_base = a / 4; m_start = a % 4; m_pos = 0;
      m_wr = (w == 1'b0); m_ddr = (d == 1'b0); m_ilv = il;
      valid = 1;
    end else if (m_act != 0) begin
      m_pos = (m_pos + ((m_ddr != 0) ? 2 : 1)) % 4;
      valid = 1;
    end
    if (valid != 0) begin
      a0 = m_base * 4 + low_of(m_start, m_pos, m_ilv);
      a1 = m_base * 4 + low_of(m_start, m_pos + 1, m_ilv);
      if (m_wr != 0) begin
        pw_valid = 1; pw_ddr = m_ddr; pw_a0 = a0; pw_a1 = a1;
      end else begin
        nxt0 = ref_mem[a0];
        nxt1 = (m_ddr != 0) ? ref_mem[a1] : ref_mem[a0];
      end
    end
    #3;
    check({tag, " high"}, q, cur0);
    #5;
    check({tag, " low"}, q, cur1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #8;
    rst_n = 1'b1;
    check("R1 reset q", q, '0);

    // R6: continuation before any load does nothing
    step(1, 1, 1, 0, 0, '0, "R6 idle");
    step(1, 0, 0, 0, 0, '0, "R6 idle");
    // R1: array reads zero after reset
    step(0, 1, 0, 0, 7, '0, "R1 read");
    step(1, 1, 1, 0, 0, '0, "R1 shown");

    // R7/R8: single-rate write then immediate read of same word
    step(0, 0, 1, 0, 5, '0, "R7 wcmd");
    step(0, 1, 1, 0, 5, {16'hdead, 16'h1234}, "R8 rd");
    step(1, 1, 1, 0, 0, '0, "R8 hit R11");

    // R3/R4: double-rate write at start 2, linear, then continuation
    step(0, 0, 0, 0, 10, '0, "R4 wcmd");
    step(1, 1, 1, 0, 0, {16'h00b1, 16'h00a0}, "R7 wdata");
    step(0, 1, 1, 0, 0, {16'h00d3, 16'h00c2}, "R9 wdata");
    // R9: commits happened, read back via array and buffer
    step(0, 1, 0, 0, 10, '0, "R3 rd");
    step(1, 1, 1, 0, 0, '0, "R6 cont rd");
    step(0, 1, 0, 1, 11, '0, "R5 rd");
    step(1, 1, 1, 1, 0, '0, "R5 cont");
    step(1, 1, 1, 1, 0, '0, "R5 wrap");

    // R2/R11: single-rate read chain with continuation
    step(0, 1, 1, 0, 9, '0, "R2 rd");
    step(1, 1, 1, 0, 0, '0, "R2 cont");
    step(1, 1, 1, 0, 0, '0, "R11 cont");

    // R9: a later write pushes the buffer into the array
    step(0, 0, 1, 0, 20, '0, "R9 wcmd");
    step(0, 1, 1, 0, 3, {16'h0, 16'h7777}, "R9 rd other");
    step(0, 0, 1, 0, 21, '0, "R9 wcmd2");
    step(0, 1, 1, 0, 20, {16'h0, 16'h8888}, "R9 rd arr");
    step(1, 1, 1, 0, 0, '0, "R9 shown");

    // R10: asynchronous release of q
    oe_n = 1'b1;
    #1;
    checks++;
    if (q === cur1) begin
      bad++;
      $display("FAIL R10: actual=%h expected=released", q);
    end
    oe_n = 1'b0;
    step(1, 1, 1, 0, 0, '0, "R10 restore");

    // Mixed random traffic compared every clock
    for (int n = 0; n < 300; n++) begin
      step(($urandom % 10) < 3, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % DEPTH, {$urandom, $urandom} , "R8 R9 random");
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule